// File: doc/BRIEF.md
# Memory-Backed Read Burst Slave with Unaligned Start

This block answers read bursts on an AXI4 read address / read data channel pair from a byte-organised internal RAM. A request may start at any byte address, not only at a multiple of the bus width. The block returns incrementing bursts of one full bus word per beat, and it places every byte in the lane chosen by its address modulo the number of lanes.

The first beat is read from the word that contains the start address. Only the lanes at or above the start offset carry requested data. Every later beat is read from the next aligned word, so a lane is never refilled from one word too far ahead. A parameter can force the lanes below the start offset on the first beat to a fixed marker byte. A simple byte write port loads the RAM before traffic starts.

Top module: `axi_unaligned_rd_slave`

## Requirements
- R1: After reset `arready` is 1 and `rvalid` is 0. A request is accepted only while no burst is in progress. The first beat is valid in the cycle after acceptance, and `arready` stays 0 until the final beat has been taken.
- R2: A request returns `arlen`+1 beats. `rlast` is 1 on the final beat only.
- R3: On the first beat of a burst with start address A and lane offset A mod NB, each lane L with L >= offset carries the RAM byte at address (A - offset) + L.
- R4: Beat k (k >= 1) carries in lane L the RAM byte at address (A - offset) + k*NB + L, modulo the RAM size. It is never read from a word beyond that one.
- R5: With `DRIVE_MARKER`=1 (the default), first-beat lanes below the offset carry `MARKER` (default 8'hDE). With `DRIVE_MARKER`=0 they carry the RAM contents.
- R6: `rdata`, `rlast` and `rid` hold their values while `rvalid` is 1 and `rready` is 0.
- R7: `rresp` is always 2'b00 (OKAY), and `rid` equals the `arid` of the request being answered.
- R8: A write on the load port (`ld_en`=1) stores `ld_data` at byte address `ld_addr`. A later burst returns the new value in lane `ld_addr` mod NB.
- R9: A burst whose start address is aligned returns RAM data in all lanes of its first beat, with no marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | RAM byte load strobe |
| ld_addr | input | ADDR_W | RAM byte load address |
| ld_data | input | 8 | RAM byte load value |
| arvalid | input | 1 | Read request valid |
| arready | output | 1 | Read request accepted when high |
| arid | input | ID_W | Request identifier |
| araddr | input | ADDR_W | Byte start address, any alignment |
| arlen | input | 8 | Beat count minus one |
| arsize | input | 3 | Beat size code, must equal log2(NB) |
| arburst | input | 2 | Burst type, must be 2'b01 (INCR) |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Read data accepted when high |
| rid | output | ID_W | Identifier of the answered request |
| rdata | output | DATA_W | Read data, one byte per lane |
| rresp | output | 2 | Response code, always OKAY |
| rlast | output | 1 | Final beat of the burst |

## Verification
The assertions assume that every request has a full-width size code and the INCR burst type. The bench issues only requests of that shape. They also assume that the load port is idle while a burst is in progress. The bench writes the RAM only before traffic starts and between two groups of bursts, and only when no beat is pending. `rready` follows a pseudo-random pattern, so bursts stall at every beat position. Start addresses cover all lane offsets, and some bursts run past the top of the RAM and wrap.

// File: rtl/axrd_pkg.sv
package axrd_pkg;

    typedef enum logic [1:0] {
        RSP_OKAY   = 2'b00,
        RSP_EXOKAY = 2'b01,
        RSP_SLVERR = 2'b10,
        RSP_DECERR = 2'b11
    } axrd_resp_e;

    typedef enum logic [1:0] {
        BT_FIXED = 2'b00,
        BT_INCR  = 2'b01,
        BT_WRAP  = 2'b10,
        BT_RSVD  = 2'b11
    } axrd_burst_e;

    // Number of the lane a byte address lands in, for a bus of 2**lane_bits lanes.
    function automatic int unsigned lane_of(int unsigned byte_addr, int unsigned lane_bits);
        return byte_addr % (1 << lane_bits);
    endfunction

endpackage

// File: rtl/axrd_byte_ram.sv
module axrd_byte_ram #(
    parameter int NB     = 4,
    parameter int LANE_W = 2,
    parameter int WORD_W = 6
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [LANE_W-1:0] wr_lane,
    input  logic [7:0]        wr_byte,
    input  logic [WORD_W-1:0] rd_word,
    output logic [NB*8-1:0]   rd_data
);
    localparam int WORDS = 1 << WORD_W;

    // One bank per lane: lane L of word W holds byte W*NB+L.
    for (genvar l = 0; l < NB; l++) begin : g_bank
        logic [7:0] bank [WORDS];
        always_ff @(posedge clk) begin
            if (wr_en && wr_lane == LANE_W'(l)) begin
                bank[wr_word] <= wr_byte;
            end
        end
        assign rd_data[8*l +: 8] = bank[rd_word];
    end
endmodule

// File: rtl/axrd_burst_ctrl.sv
module axrd_burst_ctrl
    import axrd_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int ID_W   = 4,
    parameter int LANE_W = 2,
    parameter int WORD_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arvalid,
    output logic              arready,
    input  logic [ID_W-1:0]   arid,
    input  logic [ADDR_W-1:0] araddr,
    input  logic [7:0]        arlen,
    input  logic [2:0]        arsize,
    input  logic [1:0]        arburst,
    output logic              rvalid,
    input  logic              rready,
    output logic              rlast,
    output logic [ID_W-1:0]   rid,
    output logic              beat_load,
    output logic              beat_first,
    output logic [LANE_W-1:0] beat_off,
    output logic [WORD_W-1:0] beat_word
);
    logic              busy_q;
    logic [WORD_W-1:0] word_q;
    logic [7:0]        left_q;
    logic [ID_W-1:0]   id_q;
    logic              ar_fire, r_fire;

    assign arready = !busy_q;
    assign rvalid  = busy_q;
    assign rlast   = busy_q && (left_q == 8'd0);
    assign rid     = id_q;

    assign ar_fire = arvalid && !busy_q;
    assign r_fire  = busy_q && rready;

    // A new word is fetched when a burst opens, or when a beat that is not the last one is taken.
    assign beat_load  = ar_fire || (r_fire && left_q != 8'd0);
    assign beat_first = ar_fire;
    assign beat_off   = ar_fire ? araddr[LANE_W-1:0] : '0;
    // Later beats step from the aligned word, never from the byte address.
    assign beat_word  = ar_fire ? araddr[ADDR_W-1:LANE_W] : word_q + WORD_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            word_q <= '0;
            left_q <= '0;
            id_q   <= '0;
        end else if (ar_fire) begin
            busy_q <= 1'b1;
            word_q <= araddr[ADDR_W-1:LANE_W];
            left_q <= arlen;
            id_q   <= arid;
        end else if (r_fire) begin
            if (left_q == 8'd0) begin
                busy_q <= 1'b0;
            end else begin
                word_q <= word_q + WORD_W'(1);
                left_q <= left_q - 8'd1;
            end
        end
    end

    // Independent beat counter, used only to check the burst length.
    logic [7:0] len_q, seen_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            len_q  <= '0;
            seen_q <= '0;
        end else if (ar_fire) begin
            len_q  <= arlen;
            seen_q <= '0;
        end else if (r_fire) begin
            seen_q <= seen_q + 8'd1;
        end
    end

    // R1: an accepted request yields a valid beat next cycle and blocks further requests
    p_accept_opens_r1: assert property (@(posedge clk) disable iff (rst)
        arvalid && arready |=> rvalid && !arready);

    // R2: the last beat taken closes the burst
    p_last_closes_r2: assert property (@(posedge clk) disable iff (rst)
        rvalid && rready && rlast |=> !rvalid && arready);

    // R2: the last beat arrives after exactly arlen+1 beats
    p_beat_count_r2: assert property (@(posedge clk) disable iff (rst)
        rvalid && rready && rlast |-> seen_q == len_q);

    // R3: input assumption, full-width INCR requests only
    p_req_shape_r3: assert property (@(posedge clk) disable iff (rst)
        arvalid |-> (arsize == 3'(LANE_W)) && (arburst == BT_INCR));
endmodule

// File: rtl/axrd_lane_fill.sv
module axrd_lane_fill #(
    parameter int       NB           = 4,
    parameter int       LANE_W       = 2,
    parameter bit       DRIVE_MARKER = 1'b1,
    parameter bit [7:0] MARKER       = 8'hDE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              first,
    input  logic [LANE_W-1:0] off,
    input  logic [NB*8-1:0]   raw,
    output logic [NB*8-1:0]   rdata
);
    logic [NB*8-1:0] filled;

    for (genvar l = 0; l < NB; l++) begin : g_lane
        if (DRIVE_MARKER) begin : g_mark
            assign filled[8*l +: 8] = (first && LANE_W'(l) < off) ? MARKER : raw[8*l +: 8];
        end else begin : g_pass
            assign filled[8*l +: 8] = raw[8*l +: 8];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (load) begin
            rdata <= filled;
        end
    end

    // R5: an unaligned first beat shows the marker in lane 0
    if (DRIVE_MARKER) begin : g_chk
        p_marker_lane0_r5: assert property (@(posedge clk) disable iff (rst)
            load && first && off != '0 |=> rdata[7:0] == MARKER);
    end
endmodule

// File: rtl/axi_unaligned_rd_slave.sv
module axi_unaligned_rd_slave
    import axrd_pkg::*;
#(
    parameter int       DATA_W       = 32,
    parameter int       ADDR_W       = 8,
    parameter int       ID_W         = 4,
    parameter bit       DRIVE_MARKER = 1'b1,
    parameter bit [7:0] MARKER       = 8'hDE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [7:0]        ld_data,
    input  logic              arvalid,
    output logic              arready,
    input  logic [ID_W-1:0]   arid,
    input  logic [ADDR_W-1:0] araddr,
    input  logic [7:0]        arlen,
    input  logic [2:0]        arsize,
    input  logic [1:0]        arburst,
    output logic              rvalid,
    input  logic              rready,
    output logic [ID_W-1:0]   rid,
    output logic [DATA_W-1:0] rdata,
    output logic [1:0]        rresp,
    output logic              rlast
);
    localparam int NB     = DATA_W / 8;
    localparam int LANE_W = $clog2(NB);
    localparam int WORD_W = ADDR_W - LANE_W;

    logic              beat_load, beat_first;
    logic [LANE_W-1:0] beat_off;
    logic [WORD_W-1:0] beat_word;
    logic [DATA_W-1:0] raw_word;

    axrd_byte_ram #(.NB(NB), .LANE_W(LANE_W), .WORD_W(WORD_W)) u_ram (
        .clk     (clk),
        .wr_en   (ld_en),
        .wr_word (ld_addr[ADDR_W-1:LANE_W]),
        .wr_lane (ld_addr[LANE_W-1:0]),
        .wr_byte (ld_data),
        .rd_word (beat_word),
        .rd_data (raw_word)
    );

    axrd_burst_ctrl #(.ADDR_W(ADDR_W), .ID_W(ID_W), .LANE_W(LANE_W), .WORD_W(WORD_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .arvalid    (arvalid),
        .arready    (arready),
        .arid       (arid),
        .araddr     (araddr),
        .arlen      (arlen),
        .arsize     (arsize),
        .arburst    (arburst),
        .rvalid     (rvalid),
        .rready     (rready),
        .rlast      (rlast),
        .rid        (rid),
        .beat_load  (beat_load),
        .beat_first (beat_first),
        .beat_off   (beat_off),
        .beat_word  (beat_word)
    );

    axrd_lane_fill #(.NB(NB), .LANE_W(LANE_W), .DRIVE_MARKER(DRIVE_MARKER), .MARKER(MARKER)) u_fill (
        .clk   (clk),
        .rst   (rst),
        .load  (beat_load),
        .first (beat_first),
        .off   (beat_off),
        .raw   (raw_word),
        .rdata (rdata)
    );

    assign rresp = RSP_OKAY;

    // R6: a stalled beat keeps its payload
    p_stall_hold_r6: assert property (@(posedge clk) disable iff (rst)
        rvalid && !rready |=> rvalid && $stable(rdata) && $stable(rlast) && $stable(rid));

    // R8: the load port is used only while no burst is open (input assumption)
    p_load_idle_r8: assert property (@(posedge clk) disable iff (rst)
        ld_en |-> !rvalid);
endmodule

// File: tb/axi_unaligned_rd_slave_tb.sv
module axi_unaligned_rd_slave_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NB    = 4;
    localparam int MEMSZ = 256;
    localparam int LIMIT = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_en = 1'b0;
    logic [7:0]  ld_addr = '0, ld_data = '0;
    logic        arvalid = 1'b0;
    logic        arready;
    logic [3:0]  arid = '0;
    logic [7:0]  araddr = '0, arlen = '0;
    logic [2:0]  arsize = 3'd2;
    logic [1:0]  arburst = 2'b01;
    logic        rvalid, rready = 1'b0, rlast;
    logic [3:0]  rid;
    logic [31:0] rdata;
    logic [1:0]  rresp;

    always #(CLK_PERIOD/2) clk = ~clk;

    axi_unaligned_rd_slave u_dut (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
        .arvalid(arvalid), .arready(arready), .arid(arid), .araddr(araddr),
        .arlen(arlen), .arsize(arsize), .arburst(arburst),
        .rvalid(rvalid), .rready(rready), .rid(rid), .rdata(rdata),
        .rresp(rresp), .rlast(rlast)
    );

    int n_checks = 0, n_errors = 0;
    logic [7:0] model [MEMSZ];

    int b_addr [$];
    int b_len  [$];
    int bi = 0;

    logic [31:0] q_data [$];
    logic [3:0]  q_mark [$];
    logic [3:0]  q_id   [$];
    string       q_tag  [$];

    bit running = 0, phase_done = 0, timed_out = 0, r8_phase = 0;
    int cyc = 0;
    logic [15:0] lfsr = 16'hACE1;

    bit          prev_stall = 0;
    logic [31:0] prev_data;
    logic        prev_last;
    logic [3:0]  prev_id;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] step(input logic [15:0] v);
        return v[0] ? ((v >> 1) ^ 16'hB400) : (v >> 1);
    endfunction

    // Queue the expected beats of one request.
    task automatic issue(input int a, input int len, input logic [3:0] id);
        int off = a % NB;
        int base = a - off;
        for (int k = 0; k <= len; k++) begin
            logic [31:0] w;
            logic [3:0]  m;
            m = '0;
            for (int l = 0; l < NB; l++) begin
                if (k == 0 && l < off) begin
                    w[8*l +: 8] = 8'hDE;
                    m[l] = 1'b1;
                end else begin
                    w[8*l +: 8] = model[(base + k*NB + l) % MEMSZ];
                end
            end
            q_data.push_back(w);
            q_mark.push_back(m);
            q_id.push_back(id);
            if (r8_phase)     q_tag.push_back("R8");
            else if (k > 0)   q_tag.push_back("R4");
            else if (off > 0) q_tag.push_back("R3");
            else              q_tag.push_back("R9");
        end
        araddr  = 8'(a);
        arlen   = 8'(len);
        arid    = id;
        arvalid = 1'b1;
    endtask

    // Reference model: runs on every falling edge.
    initial begin
        forever begin
            @(negedge clk);
            if (running) begin
                bit was_empty;
                cyc++;
                if (prev_stall)
                    check(rdata === prev_data && rlast === prev_last && rid === prev_id,
                          "R6", "stalled beat changed", rdata, prev_data);
                check(arready === (q_data.size() == 0), "R1", "arready", 32'(arready), 32'(q_data.size() == 0));
                check(rvalid === (q_data.size() != 0), "R1", "rvalid", 32'(rvalid), 32'(q_data.size() != 0));
                if (q_data.size() != 0 && rvalid === 1'b1) begin
                    logic [31:0] dm;
                    for (int l = 0; l < NB; l++) dm[8*l +: 8] = q_mark[0][l] ? 8'h00 : 8'hFF;
                    check((rdata & dm) === (q_data[0] & dm), q_tag[0], "data lanes", rdata & dm, q_data[0] & dm);
                    if (q_mark[0] != '0)
                        check((rdata & ~dm) === (q_data[0] & ~dm), "R5", "marker lanes", rdata & ~dm, q_data[0] & ~dm);
                    check(rlast === (q_data.size() == 1), "R2", "rlast", 32'(rlast), 32'(q_data.size() == 1));
                    check(rid === q_id[0], "R7", "rid", 32'(rid), 32'(q_id[0]));
                    check(rresp === 2'b00, "R7", "rresp", 32'(rresp), 32'd0);
                end
                lfsr   = step(lfsr);
                rready = lfsr[0] | lfsr[3];
                prev_stall = (rvalid === 1'b1) && !rready;
                prev_data  = rdata;
                prev_last  = rlast;
                prev_id    = rid;
                was_empty  = (q_data.size() == 0);
                if (rvalid === 1'b1 && rready && q_data.size() != 0) begin
                    void'(q_data.pop_front());
                    void'(q_mark.pop_front());
                    void'(q_id.pop_front());
                    void'(q_tag.pop_front());
                end
                if (arvalid) begin
                    arvalid = 1'b0;
                end else if (was_empty) begin
                    if (bi < b_addr.size()) begin
                        issue(b_addr[bi], b_len[bi], 4'(bi));
                        bi++;
                    end else begin
                        phase_done = 1;
                    end
                end
                if (cyc > LIMIT && !timed_out) begin
                    timed_out = 1;
                    check(0, "R1", "watchdog expired", 32'(cyc), 32'(LIMIT));
                end
            end
        end
    end

    initial begin
        logic [15:0] g = 16'h1D2B;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(arready === 1'b1, "R1", "reset arready", 32'(arready), 32'd1);
        check(rvalid === 1'b0, "R1", "reset rvalid", 32'(rvalid), 32'd0);
        // Preload the RAM through the load port (R8 path).
        for (int i = 0; i < MEMSZ; i++) begin
            model[i] = 8'((i * 37 + 11) ^ (i >> 3));
            ld_en = 1'b1; ld_addr = 8'(i); ld_data = model[i];
            @(negedge clk);
        end
        ld_en = 1'b0;
        // Directed cases: two-beat start at byte 1, aligned, every offset, RAM wrap.
        b_addr = '{1, 0, 3, 2, 5, 6, 253, 4, 7, 255, 128};
        b_len  = '{1, 3, 4, 0, 2, 7, 2,   0, 15, 1,  5};
        for (int i = 0; i < 12; i++) begin
            g = step(g); g = step(g);
            b_addr.push_back(int'(g[7:0]));
            b_len.push_back(int'(g[10:8]));
        end
        running = 1;
        wait (phase_done || timed_out);
        @(negedge clk);
        running = 0;
        // R8: overwrite bytes, then read them back across an unaligned burst.
        for (int i = 9; i < 15; i++) begin
            model[i] = 8'(8'hA0 + i);
            ld_en = 1'b1; ld_addr = 8'(i); ld_data = model[i];
            @(negedge clk);
        end
        ld_en = 1'b0;
        b_addr = '{9, 13};
        b_len  = '{1, 0};
        bi = 0;
        r8_phase = 1;
        phase_done = 0;
        running = 1;
        wait (phase_done || timed_out);
        @(negedge clk);
        running = 0;
        check(q_data.size() == 0, "R2", "beats left over", 32'(q_data.size()), 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule